// File: doc/BRIEF.md
# Direct-Mapped Cache with Victim Buffer

This block is a small cache built from a direct-mapped primary array and a fully associative victim buffer of a few entries. A processor sends single-line reads and writes on a valid/ready request port and receives one response per request. A line is one data word, and the request address is a line address. Both structures are searched with the same address in the same cycle. A hit in either one is answered one cycle after the request is accepted. A hit in the victim buffer exchanges the requested line with the line that occupies its primary set.

When both structures miss, the block stops accepting requests. It holds a read request on the memory port until the fill data arrives. The filled line goes into the primary array. The line it displaces is pushed into the victim buffer. If that push overwrites a modified line, the overwritten line is sent to memory as a single-cycle write. Clean lines that leave the victim buffer are discarded without a write. Memory accepts write-backs unconditionally.

Top module: `victim_cache`

## Requirements
- R1: After reset every line in both structures is invalid, `req_ready` is 1, and `rsp_valid`, `mem_rd_req` and `mem_wr_valid` are all 0.
- R2: The primary set index is the low `IDX_W` bits of the line address, and the tag is the remaining upper bits. A request that hits the primary array gives `rsp_valid` exactly one cycle after acceptance and issues no memory read.
- R3: A request that misses the primary array and hits the victim buffer is answered exactly one cycle after acceptance with no memory read. The requested line takes the primary set. The former primary line, if valid, takes the victim slot that was hit.
- R4: A request that misses both structures drives `req_ready` to 0 from the next cycle. `mem_rd_req` is held with `mem_rd_addr` equal to the request address until `mem_rd_valid` is sampled. The response follows one cycle later.
- R5: When a fill displaces a valid primary line, that line is written into the victim slot chosen by a rotating pointer. The pointer starts at 0 and advances by one, modulo the buffer depth, on each such insertion. A fill into an invalid primary set inserts nothing and leaves the pointer unchanged.
- R6: If a fill insertion overwrites a valid dirty victim entry, `mem_wr_valid` pulses for one cycle with that entry's address and data, in the same cycle as the response. No other event produces a memory write.
- R7: A read response carries the line data. A write response echoes the written data. A write replaces the line and marks it dirty in every case: a primary hit, a victim hit (the swap happens first) and a fill.
- R8: A line address is never held in both structures or in two victim slots at once. A line is therefore only fetched from memory when it is in neither structure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high together with `req_valid` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Line address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Response pulse |
| rsp_rdata | output | DATA_W | Read data, or the echoed write data |
| mem_rd_req | output | 1 | Fill read request, held until data returns |
| mem_rd_addr | output | ADDR_W | Fill line address |
| mem_rd_valid | input | 1 | Fill data present |
| mem_rd_data | input | DATA_W | Fill data |
| mem_wr_valid | output | 1 | Write-back pulse |
| mem_wr_addr | output | ADDR_W | Write-back line address |
| mem_wr_data | output | DATA_W | Write-back data |

## Verification
Hits in either structure must show `rsp_valid` on the first falling edge after the accepting rising edge. At that same sample `mem_rd_req` must be low. On a double miss, that first sample must instead show `mem_rd_req` with the request address and no response. The bench returns fill data a few cycles later. It then expects the response, and any write-back, exactly one falling edge after the edge that captured `mem_rd_valid`. A bench model predicts for every access which structure should hit, the response data and any write-back. Each of these results is compared only at the one sample where it is due.

// File: rtl/victim_cache_pkg.sv
package victim_cache_pkg;
  typedef enum logic {ST_IDLE, ST_FILL} vc_state_t;
endpackage

// File: rtl/vc_primary.sv
module vc_primary #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       lk_addr,
  output logic                    hit,
  output logic                    old_valid,
  output logic                    old_dirty,
  output logic [ADDR_W-1:0]       old_addr,
  output logic [DATA_W-1:0]       old_data,
  input  logic                    wr_en,
  input  logic [ADDR_W-IDX_W-1:0] wr_tag,
  input  logic [DATA_W-1:0]       wr_data,
  input  logic                    wr_dirty
);
  localparam int SETS  = 1 << IDX_W;
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [SETS-1:0]  valid_q, dirty_q;
  logic [TAG_W-1:0] tag_q  [SETS];
  logic [DATA_W-1:0] data_q [SETS];

  logic [IDX_W-1:0] idx;
  assign idx       = lk_addr[IDX_W-1:0];
  assign old_valid = valid_q[idx];
  assign old_dirty = dirty_q[idx];
  assign old_addr  = {tag_q[idx], idx};
  assign old_data  = data_q[idx];
  assign hit       = valid_q[idx] && (tag_q[idx] == lk_addr[ADDR_W-1:IDX_W]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (wr_en) begin
      valid_q[idx] <= 1'b1;
      dirty_q[idx] <= wr_dirty;
      tag_q[idx]   <= wr_tag;
      data_q[idx]  <= wr_data;
    end
  end
endmodule

// File: rtl/vc_victim.sv
module vc_victim #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        lk_addr,
  output logic                     hit,
  output logic [$clog2(DEPTH)-1:0] hit_slot,
  output logic [DATA_W-1:0]        hit_data,
  output logic                     hit_dirty,
  output logic [$clog2(DEPTH)-1:0] ptr,
  output logic                     ev_valid,
  output logic                     ev_dirty,
  output logic [ADDR_W-1:0]        ev_addr,
  output logic [DATA_W-1:0]        ev_data,
  input  logic                     wr_en,
  input  logic [$clog2(DEPTH)-1:0] wr_slot,
  input  logic                     wr_valid,
  input  logic                     wr_dirty,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic                     ptr_adv
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [DEPTH-1:0]  valid_q, dirty_q, match;
  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];
  logic [PTR_W-1:0]  ptr_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign match[g] = valid_q[g] && (addr_q[g] == lk_addr);
  end

  always_comb begin
    hit_slot = '0;
    for (int i = 0; i < DEPTH; i++)
      if (match[i]) hit_slot = PTR_W'(i);
  end

  assign hit       = |match;
  assign hit_data  = data_q[hit_slot];
  assign hit_dirty = dirty_q[hit_slot];
  assign ptr       = ptr_q;
  assign ev_valid  = valid_q[ptr_q];
  assign ev_dirty  = dirty_q[ptr_q];
  assign ev_addr   = addr_q[ptr_q];
  assign ev_data   = data_q[ptr_q];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
      ptr_q   <= '0;
    end else begin
      if (wr_en) begin
        valid_q[wr_slot] <= wr_valid;
        dirty_q[wr_slot] <= wr_dirty;
        addr_q[wr_slot]  <= wr_addr;
        data_q[wr_slot]  <= wr_data;
      end
      if (ptr_adv) ptr_q <= (ptr_q == PTR_W'(DEPTH - 1)) ? '0 : ptr_q + 1'b1;
    end
  end

  // R8: a line address sits in at most one victim slot
  assert_single_slot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));
endmodule

// File: rtl/victim_cache.sv
module victim_cache
  import victim_cache_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int IDX_W    = 3,
  parameter int VB_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_rd_req,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rd_valid,
  input  logic [DATA_W-1:0] mem_rd_data,
  output logic              mem_wr_valid,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [DATA_W-1:0] mem_wr_data
);
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam int PTR_W = $clog2(VB_DEPTH);

  function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:IDX_W];
  endfunction

  vc_state_t         state_q;
  logic              pend_wr_q;
  logic [ADDR_W-1:0] pend_addr_q;
  logic [DATA_W-1:0] pend_wdata_q;

  logic [ADDR_W-1:0] lk_addr;
  logic              req_fire, fill_done;
  logic              p_hit, p_old_valid, p_old_dirty;
  logic [ADDR_W-1:0] p_old_addr;
  logic [DATA_W-1:0] p_old_data;
  logic              v_hit, v_hit_dirty;
  logic [PTR_W-1:0]  v_hit_slot, v_ptr;
  logic [DATA_W-1:0] v_hit_data;
  logic              v_ev_valid, v_ev_dirty;
  logic [ADDR_W-1:0] v_ev_addr;
  logic [DATA_W-1:0] v_ev_data;

  // named events
  logic ev_prim_hit, ev_swap, ev_miss, ev_insert, ev_writeback;

  logic              pw_en, pw_dirty;
  logic [DATA_W-1:0] pw_data;
  logic              vw_en, vw_valid;
  logic [PTR_W-1:0]  vw_slot;
  logic [DATA_W-1:0] rsp_d;

  assign req_ready    = (state_q == ST_IDLE);
  assign req_fire     = req_valid && req_ready;
  assign fill_done    = (state_q == ST_FILL) && mem_rd_valid;
  assign lk_addr      = (state_q == ST_FILL) ? pend_addr_q : req_addr;
  assign ev_prim_hit  = req_fire && p_hit;
  assign ev_swap      = req_fire && !p_hit && v_hit;
  assign ev_miss      = req_fire && !p_hit && !v_hit;
  assign ev_insert    = fill_done && p_old_valid;
  assign ev_writeback = ev_insert && v_ev_valid && v_ev_dirty;
  assign mem_rd_req   = (state_q == ST_FILL);
  assign mem_rd_addr  = pend_addr_q;

  vc_primary #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_prim (
    .clk(clk), .rst_n(rst_n), .lk_addr(lk_addr), .hit(p_hit),
    .old_valid(p_old_valid), .old_dirty(p_old_dirty), .old_addr(p_old_addr),
    .old_data(p_old_data), .wr_en(pw_en), .wr_tag(tag_of(lk_addr)),
    .wr_data(pw_data), .wr_dirty(pw_dirty)
  );

  vc_victim #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(VB_DEPTH)) u_vict (
    .clk(clk), .rst_n(rst_n), .lk_addr(lk_addr), .hit(v_hit),
    .hit_slot(v_hit_slot), .hit_data(v_hit_data), .hit_dirty(v_hit_dirty),
    .ptr(v_ptr), .ev_valid(v_ev_valid), .ev_dirty(v_ev_dirty),
    .ev_addr(v_ev_addr), .ev_data(v_ev_data), .wr_en(vw_en),
    .wr_slot(vw_slot), .wr_valid(vw_valid), .wr_dirty(p_old_dirty),
    .wr_addr(p_old_addr), .wr_data(p_old_data), .ptr_adv(ev_insert)
  );

  always_comb begin
    pw_en    = 1'b0;
    pw_dirty = 1'b0;
    pw_data  = p_old_data;
    vw_en    = 1'b0;
    vw_valid = p_old_valid;
    vw_slot  = v_hit_slot;
    rsp_d    = p_old_data;
    if (ev_prim_hit) begin
      pw_en    = req_write;
      pw_dirty = 1'b1;
      pw_data  = req_wdata;
      rsp_d    = req_write ? req_wdata : p_old_data;
    end else if (ev_swap) begin
      pw_en    = 1'b1;
      pw_dirty = req_write || v_hit_dirty;
      pw_data  = req_write ? req_wdata : v_hit_data;
      vw_en    = 1'b1;
      rsp_d    = pw_data;
    end else if (fill_done) begin
      pw_en    = 1'b1;
      pw_dirty = pend_wr_q;
      pw_data  = pend_wr_q ? pend_wdata_q : mem_rd_data;
      vw_en    = p_old_valid;
      vw_slot  = v_ptr;
      rsp_d    = pw_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      rsp_valid    <= 1'b0;
      mem_wr_valid <= 1'b0;
      pend_wr_q    <= 1'b0;
      pend_addr_q  <= '0;
      pend_wdata_q <= '0;
      rsp_rdata    <= '0;
      mem_wr_addr  <= '0;
      mem_wr_data  <= '0;
    end else begin
      rsp_valid    <= ev_prim_hit || ev_swap || fill_done;
      mem_wr_valid <= ev_writeback;
      if (ev_prim_hit || ev_swap || fill_done) rsp_rdata <= rsp_d;
      if (ev_writeback) begin
        mem_wr_addr <= v_ev_addr;
        mem_wr_data <= v_ev_data;
      end
      if (ev_miss) begin
        state_q      <= ST_FILL;
        pend_wr_q    <= req_write;
        pend_addr_q  <= req_addr;
        pend_wdata_q <= req_wdata;
      end else if (fill_done) begin
        state_q <= ST_IDLE;
      end
    end
  end

  // R8: primary and victim never hold the same line
  assert_exclusive_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(p_hit && v_hit));
  // R2, R3: any hit is answered on the next cycle
  assert_hit_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_prim_hit || ev_swap) |=> (rsp_valid && !mem_rd_req));
  // R4: a double miss closes the request port and asks memory
  assert_miss_stalls_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_miss |=> (!req_ready && mem_rd_req && !rsp_valid));
  // R4: the fill address is stable while waiting
  assert_fill_addr_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req && !mem_rd_valid) |=> (mem_rd_req && $stable(mem_rd_addr)));
  // R6: a write-back only accompanies a fill response
  assert_wb_with_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid |-> rsp_valid);
endmodule

// File: tb/victim_cache_tb.sv
module victim_cache_tb;
  localparam int AW = 8, DW = 32, IW = 3, VD = 4;
  localparam int SETS = 1 << IW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic mem_rd_valid = 1'b0;
  logic [DW-1:0] mem_rd_data = '0;
  logic req_ready, rsp_valid, mem_rd_req, mem_wr_valid;
  logic [DW-1:0] rsp_rdata, mem_wr_data;
  logic [AW-1:0] mem_rd_addr, mem_wr_addr;

  always #2.5 clk = ~clk;

  victim_cache #(.ADDR_W(AW), .DATA_W(DW), .IDX_W(IW), .VB_DEPTH(VD)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_rd_req(mem_rd_req),
    .mem_rd_addr(mem_rd_addr), .mem_rd_valid(mem_rd_valid),
    .mem_rd_data(mem_rd_data), .mem_wr_valid(mem_wr_valid),
    .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  // reference state
  logic [DW-1:0] mem [1 << AW];
  bit            pv [SETS], pdy [SETS];
  logic [AW-1:0] pa [SETS];
  logic [DW-1:0] pd [SETS];
  bit            vv [VD], vdy [VD];
  logic [AW-1:0] va [VD];
  logic [DW-1:0] vdat [VD];
  int            vptr = 0;

  function automatic logic [DW-1:0] seed_word(input logic [AW-1:0] a);
    return {a, 8'h5A, ~a, a ^ 8'hC3};
  endfunction

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] wd);
    int idx = int'(a[IW-1:0]);
    int kind = 2, slot = 0;
    bit exp_wb = 0;
    logic [AW-1:0] wb_a = '0;
    logic [DW-1:0] wb_d = '0, exp_rd;
    bit od; logic [AW-1:0] oa; logic [DW-1:0] odat; bit ov;
    if (pv[idx] && pa[idx] == a) kind = 0;
    else for (int s = 0; s < VD; s++) if (vv[s] && va[s] == a) begin kind = 1; slot = s; end
    ov = pv[idx]; oa = pa[idx]; odat = pd[idx]; od = pdy[idx];
    if (kind == 0) begin
      exp_rd = wr ? wd : pd[idx];
      if (wr) begin pd[idx] = wd; pdy[idx] = 1; end
    end else if (kind == 1) begin
      exp_rd = wr ? wd : vdat[slot];
      pdy[idx] = wr | vdy[slot]; pd[idx] = exp_rd; pa[idx] = a; pv[idx] = 1;
      vv[slot] = ov; va[slot] = oa; vdat[slot] = odat; vdy[slot] = od;
    end else begin
      exp_rd = wr ? wd : mem[a];
      if (ov) begin
        if (vv[vptr] && vdy[vptr]) begin exp_wb = 1; wb_a = va[vptr]; wb_d = vdat[vptr]; end
        vv[vptr] = 1; va[vptr] = oa; vdat[vptr] = odat; vdy[vptr] = od;
        vptr = (vptr + 1) % VD;
      end
      pv[idx] = 1; pa[idx] = a; pd[idx] = exp_rd; pdy[idx] = wr;
    end
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_valid = 0;
    if (kind != 2) begin
      // R2 (primary hit) / R3 (victim hit): one-cycle answer, no fetch, R8
      check(rsp_valid && !mem_rd_req, kind == 0 ? "R2 hit latency" : "R3 swap latency",
            {30'd0, rsp_valid, mem_rd_req}, 32'd2);
    end else begin
      check(mem_rd_req && !rsp_valid && !req_ready && mem_rd_addr == a,
            "R4 fill request", {24'd0, mem_rd_addr}, {24'd0, a});
      @(negedge clk); @(negedge clk);
      mem_rd_valid = 1; mem_rd_data = mem[a];
      @(negedge clk);
      mem_rd_valid = 0;
      check(rsp_valid, "R4 fill response", {31'd0, rsp_valid}, 32'd1);
    end
    // R7 data (read data or echoed write data)
    check(rsp_rdata == exp_rd, "R7 response data", rsp_rdata, exp_rd);
    // R5/R6 write-back of a dirty victim only
    check(mem_wr_valid == exp_wb && (!exp_wb || (mem_wr_addr == wb_a && mem_wr_data == wb_d)),
          "R6 write-back", exp_wb ? mem_wr_data : {31'd0, mem_wr_valid},
          exp_wb ? wb_d : 32'd0);
    if (exp_wb) mem[wb_a] = wb_d;
  endtask

  initial begin
    for (int i = 0; i < (1 << AW); i++) mem[i] = seed_word(AW'(i));
    for (int i = 0; i < SETS; i++) begin pv[i] = 0; pdy[i] = 0; pa[i] = '0; pd[i] = '0; end
    for (int i = 0; i < VD; i++) begin vv[i] = 0; vdy[i] = 0; va[i] = '0; vdat[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(req_ready && !rsp_valid && !mem_rd_req && !mem_wr_valid, "R1 reset outputs",
          {28'd0, req_ready, rsp_valid, mem_rd_req, mem_wr_valid}, 32'h8);
    // directed: conflict chain on set 0 (R5 pointer, R3 swap, R6 dirty/clean)
    access(1, 8'h00, 32'hAAAA_0000);   // miss, dirty
    access(0, 8'h08, 0);                // miss, 0x00 -> slot 0
    access(0, 8'h00, 0);                // victim hit, swap
    access(1, 8'h00, 32'hAAAA_1111);   // primary hit write
    access(0, 8'h10, 0);                // miss, 0x00 -> slot 1
    access(1, 8'h08, 32'hBBBB_0000);   // victim hit write after swap
    access(0, 8'h18, 0); access(0, 8'h20, 0); access(0, 8'h28, 0);
    access(0, 8'h30, 0); access(0, 8'h38, 0);  // wrap pointer, write-backs
    access(0, 8'h00, 0);                 // refetch after write-back
    access(0, 8'h09, 0);                 // R5: fill into empty set inserts nothing
    void'($urandom(32'd1234));
    for (int n = 0; n < 400; n++) begin
      logic [31:0] r = $urandom();
      logic [AW-1:0] a = {2'b00, r[2:0], 1'b0, r[4:3]};
      access(r[9:8] == 2'b00 || r[9:8] == 2'b01 && r[10], a, $urandom());
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=0", 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule